// File: doc/BRIEF.md
# Ethernet PHY Control Register Resolver

This block holds the primary control register of a 10/100 Ethernet transceiver. The register is reached over a plain management port with an address, a write strobe and 16-bit write and read data. The block combines the register fields with four strap pins and resolves the effective operating mode. One pin picks hardware or software priority, and the other three set speed, duplex and auto-negotiation use. From this it drives the resolved speed, duplex and auto-negotiation enable, a one-cycle restart strobe for the negotiation engine, a power-down level, an error-clear strobe for wake-up, and a data-path output enable that stands in for the tri-state pads.

The block also contains a collision-test generator for loopback diagnostics. While loopback and the collision-test field are both set, a transmit enable held high for a fixed number of clocks raises the collision output. The output drops on the first clock after transmit enable falls. The negotiation engine itself, the analog front end and the real pads are not part of this block.

Register field positions inside the 16-bit word are: loopback 14, speed 13 (1 = 100 Mbps), auto-negotiation enable 12, power-down 11, isolate 10, restart 9, duplex 8 (1 = full), collision test 7. Bit 15 and bits 6..0 are unused.

Top module: `phy_ctrl_resolver`

## Requirements
- R1: After reset the register reads 0x3000 (auto-negotiation on, 100 Mbps, half duplex, everything else clear). `anEnable`=1, `dataOe`=1, and `speed100`, `fullDuplex`, `anRestart`, `powerDown`, `errClear` and `colTest` are all 0.
- R2: In software priority (`hwPrioSel`=0) with bit 12 clear, `speed100` follows bit 13 and `fullDuplex` follows bit 8 from the cycle after the write.
- R3: Whenever the resolved auto-negotiation enable is 1, bits 13 and 8 have no effect and `speed100` and `fullDuplex` are both 0.
- R4: With `hwPrioSel`=1, `speed100`, `fullDuplex` and `anEnable` follow `pinSpeed100`, `pinFullDuplex` and `pinAnEnable`, and bits 13, 12 and 8 have no effect.
- R5: A write at the register address with bit 9 set pulses `anRestart` for one cycle, but only if auto-negotiation resolves as enabled for the written value (bit 12 in software priority, `pinAnEnable` in hardware priority). Bit 9 always reads 0.
- R6: Bit 15 and bits 6..0 always read 0, whatever was written.
- R7: With bit 10 set, `dataOe` is 0 and `txEn` is ignored, so no test collision can arise. Register access still works.
- R8: With bit 11 set, `powerDown`=1 and `dataOe`=0. In the cycle after a write clears bit 11, `errClear` is 1 and `dataOe` is still 0. In the cycle after that, `errClear` is 0 and `dataOe` is back to 1 (if isolate is clear).
- R9: With bits 14 and 7 set and the data path enabled, `colTest` rises after the COL_DELAY-th clock edge that samples `txEn` high. It falls on the first edge that samples `txEn` low.
- R10: If either bit 14 or bit 7 is clear, `colTest` stays 0 however long `txEn` is held high.
- R11: While bit 14 (loopback) is set, `fullDuplex` is 0 regardless of bit 8 or `pinFullDuplex`.
- R12: Writes to any address other than REG_ADDR leave the register unchanged, and reads at those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also used as the bit-time base for the collision test |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Management register address |
| regWe | input | 1 | Management write strobe |
| regWdata | input | 16 | Management write data |
| regRdata | output | 16 | Management read data (combinational) |
| hwPrioSel | input | 1 | 1 = strap pins decide the mode, 0 = register decides |
| pinSpeed100 | input | 1 | Speed strap, 1 = 100 Mbps |
| pinFullDuplex | input | 1 | Duplex strap, 1 = full |
| pinAnEnable | input | 1 | Auto-negotiation strap |
| txEn | input | 1 | Transmit enable from the MAC side |
| speed100 | output | 1 | Resolved forced speed |
| fullDuplex | output | 1 | Resolved forced duplex |
| anEnable | output | 1 | Resolved auto-negotiation enable |
| anRestart | output | 1 | One-cycle auto-negotiation restart strobe |
| powerDown | output | 1 | Low-power request |
| dataOe | output | 1 | Data-path output enable (0 = isolated) |
| errClear | output | 1 | One-cycle error-clear strobe on wake-up |
| colTest | output | 1 | Test collision output |

## Verification
The bench sets COL_DELAY to 16 instead of the default 64, which keeps the rise-at-count and release-on-fall edges of the collision test within a short run while the counting logic stays the same. REG_ADDR keeps its default of 0, and ADDR_W stays at 5, so writes and reads at address 1 can check address decoding. With these values the bench can sweep hardware versus software priority, the restart gating in both priority modes, the two-cycle wake-up ordering, and isolation during a collision test.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

  localparam int unsigned REG_W = 16;

  localparam int unsigned BIT_LOOP  = 14;
  localparam int unsigned BIT_SPEED = 13;
  localparam int unsigned BIT_AN    = 12;
  localparam int unsigned BIT_PWRDN = 11;
  localparam int unsigned BIT_ISO   = 10;
  localparam int unsigned BIT_RESTART = 9;
  localparam int unsigned BIT_DUPLEX = 8;
  localparam int unsigned BIT_COLTST = 7;

  typedef struct packed {
    logic loopback;
    logic speedSel;
    logic anEn;
    logic pwrDn;
    logic isolate;
    logic duplexSel;
    logic colTst;
  } ctrlBits_t;

  localparam ctrlBits_t CTRL_RESET = '{
    loopback: 1'b0, speedSel: 1'b1, anEn: 1'b1, pwrDn: 1'b0,
    isolate: 1'b0, duplexSel: 1'b0, colTst: 1'b0
  };

  typedef struct packed {
    logic pathEnable;
    logic colArm;
  } dpStrobe_t;

endpackage

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              hwPrioSel,
  input  logic              pinSpeed100,
  input  logic              pinFullDuplex,
  input  logic              pinAnEnable,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              anEnable,
  output logic              anRestart,
  output logic              powerDown,
  output logic              errClear,
  output dpStrobe_t         strobes
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  ctrlBits_t cfg;
  ctrlBits_t cfgNext;
  logic      wrHit;
  logic      anForWrite;
  logic      restartQ;
  logic      wakeQ;
  logic      unusedWdata;

  assign wrHit       = regWe && (regAddr == HIT_ADDR);
  assign unusedWdata = ^{regWdata[15], regWdata[6:0]};

  always_comb begin
    cfgNext.loopback  = regWdata[BIT_LOOP];
    cfgNext.speedSel  = regWdata[BIT_SPEED];
    cfgNext.anEn      = regWdata[BIT_AN];
    cfgNext.pwrDn     = regWdata[BIT_PWRDN];
    cfgNext.isolate   = regWdata[BIT_ISO];
    cfgNext.duplexSel = regWdata[BIT_DUPLEX];
    cfgNext.colTst    = regWdata[BIT_COLTST];
  end

  // Negotiation enable as it will stand after this write.
  assign anForWrite = hwPrioSel ? pinAnEnable : cfgNext.anEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg      <= CTRL_RESET;
      restartQ <= 1'b0;
      wakeQ    <= 1'b0;
    end else begin
      restartQ <= wrHit && regWdata[BIT_RESTART] && anForWrite;
      wakeQ    <= wrHit && cfg.pwrDn && !cfgNext.pwrDn;
      if (wrHit) cfg <= cfgNext;
    end
  end

  // Mode resolution: strap pins win in hardware priority.
  always_comb begin
    anEnable = hwPrioSel ? pinAnEnable : cfg.anEn;
    if (anEnable) begin
      speed100   = 1'b0;
      fullDuplex = 1'b0;
    end else if (hwPrioSel) begin
      speed100   = pinSpeed100;
      fullDuplex = pinFullDuplex && !cfg.loopback;
    end else begin
      speed100   = cfg.speedSel;
      fullDuplex = cfg.duplexSel && !cfg.loopback;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == HIT_ADDR) begin
      regRdata[BIT_LOOP]   = cfg.loopback;
      regRdata[BIT_SPEED]  = cfg.speedSel;
      regRdata[BIT_AN]     = cfg.anEn;
      regRdata[BIT_PWRDN]  = cfg.pwrDn;
      regRdata[BIT_ISO]    = cfg.isolate;
      regRdata[BIT_DUPLEX] = cfg.duplexSel;
      regRdata[BIT_COLTST] = cfg.colTst;
    end
  end

  assign anRestart          = restartQ;
  assign powerDown          = cfg.pwrDn;
  assign errClear           = wakeQ;
  assign strobes.pathEnable = !cfg.pwrDn && !cfg.isolate && !wakeQ;
  assign strobes.colArm     = cfg.loopback && cfg.colTst;

endmodule

// File: rtl/phy_ctrl_coltest.sv
module phy_ctrl_coltest
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned COL_DELAY = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEn,
  input  dpStrobe_t strobes,
  output logic      dataOe,
  output logic      colTest
);

  localparam int unsigned CNT_W = $clog2(COL_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(COL_DELAY - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(COL_DELAY);

  logic             txEnGated;
  logic             running;
  logic [CNT_W-1:0] bitCnt;
  logic             colQ;

  // Isolation drops the transmit enable before it reaches the counter.
  assign txEnGated = txEn && strobes.pathEnable;
  assign running   = txEnGated && strobes.colArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      colQ   <= 1'b0;
    end else if (running) begin
      if (bitCnt != CNT_MAX) bitCnt <= bitCnt + 1'b1;
      colQ <= colQ || (bitCnt == CNT_FIRE);
    end else begin
      bitCnt <= '0;
      colQ   <= 1'b0;
    end
  end

  assign dataOe  = strobes.pathEnable;
  assign colTest = colQ && strobes.colArm && strobes.pathEnable;

endmodule

// File: rtl/phy_ctrl_resolver.sv
module phy_ctrl_resolver
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned REG_ADDR  = 0,
  parameter int unsigned COL_DELAY = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              hwPrioSel,
  input  logic              pinSpeed100,
  input  logic              pinFullDuplex,
  input  logic              pinAnEnable,
  input  logic              txEn,
  output logic              speed100,
  output logic              fullDuplex,
  output logic              anEnable,
  output logic              anRestart,
  output logic              powerDown,
  output logic              dataOe,
  output logic              errClear,
  output logic              colTest
);

  dpStrobe_t strobes;

  phy_ctrl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .hwPrioSel(hwPrioSel), .pinSpeed100(pinSpeed100),
    .pinFullDuplex(pinFullDuplex), .pinAnEnable(pinAnEnable),
    .speed100(speed100), .fullDuplex(fullDuplex), .anEnable(anEnable),
    .anRestart(anRestart), .powerDown(powerDown), .errClear(errClear),
    .strobes(strobes)
  );

  phy_ctrl_coltest #(.COL_DELAY(COL_DELAY)) u_col (
    .clk(clk), .rstN(rstN), .txEn(txEn), .strobes(strobes),
    .dataOe(dataOe), .colTest(colTest)
  );

endmodule

// File: rtl/phy_ctrl_checker.sv
module phy_ctrl_checker #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_ADDR = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [15:0]       regWdata,
  input logic [15:0]       regRdata,
  input logic              hwPrioSel,
  input logic              pinAnEnable,
  input logic              txEn,
  input logic              speed100,
  input logic              fullDuplex,
  input logic              anEnable,
  input logic              anRestart,
  input logic              powerDown,
  input logic              dataOe,
  input logic              errClear,
  input logic              colTest
);

  localparam logic [ADDR_W-1:0] CHK_ADDR = ADDR_W'(REG_ADDR);

  p_forced_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    anEnable |-> (!speed100 && !fullDuplex));

  p_hw_an_pin_r4: assert property (@(posedge clk) disable iff (!rstN)
    hwPrioSel |-> (anEnable == pinAnEnable));

  p_restart_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    anRestart |-> $past(regWe && (regAddr == CHK_ADDR) && regWdata[9]));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[15] == 1'b0) && (regRdata[9] == 1'b0) && (regRdata[6:0] == 7'd0));

  p_pd_isolates_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !dataOe);

  p_wake_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    errClear |-> (!dataOe && !powerDown));

  p_col_needs_path_r9: assert property (@(posedge clk) disable iff (!rstN)
    colTest |-> dataOe);

  p_col_rise_txen_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colTest) |-> $past(txEn));

  p_loop_half_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr == CHK_ADDR) && regRdata[14]) |-> !fullDuplex);

endmodule

bind phy_ctrl_resolver phy_ctrl_checker #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .hwPrioSel(hwPrioSel),
  .pinAnEnable(pinAnEnable), .txEn(txEn), .speed100(speed100),
  .fullDuplex(fullDuplex), .anEnable(anEnable), .anRestart(anRestart),
  .powerDown(powerDown), .dataOe(dataOe), .errClear(errClear),
  .colTest(colTest)
);

// File: tb/tb_phy_ctrl_resolver.sv
`timescale 1ns/100ps
module tb_phy_ctrl_resolver;

  localparam int COL_D = 16;
  localparam int ADDR_W = 5;

  typedef struct {
    string       req;
    logic [23:0] exp;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWe = 1'b0;
  logic [15:0]       regWdata = '0;
  logic [15:0]       regRdata;
  logic              hwPrioSel = 1'b0;
  logic              pinSpeed100 = 1'b0;
  logic              pinFullDuplex = 1'b0;
  logic              pinAnEnable = 1'b0;
  logic              txEn = 1'b0;
  logic speed100, fullDuplex, anEnable, anRestart, powerDown, dataOe, errClear, colTest;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  phy_ctrl_resolver #(.ADDR_W(ADDR_W), .REG_ADDR(0), .COL_DELAY(COL_D)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .hwPrioSel(hwPrioSel),
    .pinSpeed100(pinSpeed100), .pinFullDuplex(pinFullDuplex),
    .pinAnEnable(pinAnEnable), .txEn(txEn), .speed100(speed100),
    .fullDuplex(fullDuplex), .anEnable(anEnable), .anRestart(anRestart),
    .powerDown(powerDown), .dataOe(dataOe), .errClear(errClear),
    .colTest(colTest)
  );

  function automatic logic [23:0] ev(logic [15:0] rd, logic s, logic f, logic a,
                                     logic r, logic p, logic o, logic e, logic c);
    return {rd, s, f, a, r, p, o, e, c};
  endfunction

  // Monitor: pops expected items and compares away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [23:0] act;
        it  = sb.pop_front();
        act = {regRdata, speed100, fullDuplex, anEnable, anRestart,
               powerDown, dataOe, errClear, colTest};
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expectNow(string req, logic [23:0] e);
    sb.push_back('{req: req, exp: e});
    cyc();
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    regAddr  = a;
    regWdata = d;
    regWe    = 1'b1;
    cyc();
    regWe   = 1'b0;
    regAddr = '0;
  endtask

  initial begin
    #10000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    expectNow("R1 reset", ev(16'h3000, 0,0,1,0,0,1,0,0));

    wr(0, 16'h2100);
    expectNow("R2 forced 100 full", ev(16'h2100, 1,1,0,0,0,1,0,0));
    wr(0, 16'h0000);
    expectNow("R2 forced 10 half", ev(16'h0000, 0,0,0,0,0,1,0,0));
    wr(0, 16'h3100);
    expectNow("R3 an ignores 13/8", ev(16'h3100, 0,0,1,0,0,1,0,0));

    wr(0, 16'h3300);
    expectNow("R5 restart pulse", ev(16'h3100, 0,0,1,1,0,1,0,0));
    expectNow("R5 restart one cycle", ev(16'h3100, 0,0,1,0,0,1,0,0));
    wr(0, 16'h0200);
    expectNow("R5 no restart when an off", ev(16'h0000, 0,0,0,0,0,1,0,0));

    wr(0, 16'hFFFF);
    expectNow("R6 reserved read zero", ev(16'h7D80, 0,0,1,1,1,0,0,0));
    wr(0, 16'h0000);
    expectNow("R8 wake errClear", ev(16'h0000, 0,0,0,0,0,0,1,0));
    expectNow("R8 wake dataOe back", ev(16'h0000, 0,0,0,0,0,1,0,0));
    wr(0, 16'h0800);
    expectNow("R8 power-down", ev(16'h0800, 0,0,0,0,1,0,0,0));
    wr(0, 16'h0000);
    expectNow("R8 wake errClear again", ev(16'h0000, 0,0,0,0,0,0,1,0));

    hwPrioSel = 1'b1; pinSpeed100 = 1'b1; pinFullDuplex = 1'b1; pinAnEnable = 1'b0;
    expectNow("R4 pins decide", ev(16'h0000, 1,1,0,0,0,1,0,0));
    wr(0, 16'h3100);
    expectNow("R4 reg bits no effect", ev(16'h3100, 1,1,0,0,0,1,0,0));
    wr(0, 16'h3300);
    expectNow("R5 hw no restart pin off", ev(16'h3100, 1,1,0,0,0,1,0,0));
    pinAnEnable = 1'b1;
    expectNow("R4 pin an on", ev(16'h3100, 0,0,1,0,0,1,0,0));
    wr(0, 16'h0200);
    expectNow("R5 hw restart pin on", ev(16'h0000, 0,0,1,1,0,1,0,0));
    pinAnEnable = 1'b0; pinSpeed100 = 1'b0;
    wr(0, 16'h4000);
    expectNow("R11 hw loopback half", ev(16'h4000, 0,0,0,0,0,1,0,0));
    hwPrioSel = 1'b0; pinFullDuplex = 1'b0;

    wr(0, 16'h4100);
    expectNow("R11 sw loopback half", ev(16'h4100, 0,0,0,0,0,1,0,0));

    wr(0, 16'h0400);
    expectNow("R7 isolate", ev(16'h0400, 0,0,0,0,0,0,0,0));
    wr(0, 16'h4480);
    txEn = 1'b1;
    repeat (COL_D + 2) cyc();
    expectNow("R7 txEn ignored", ev(16'h4480, 0,0,0,0,0,0,0,0));
    txEn = 1'b0;

    wr(0, 16'h4080);
    expectNow("R9 armed", ev(16'h4080, 0,0,0,0,0,1,0,0));
    txEn = 1'b1;
    repeat (COL_D - 1) cyc();
    expectNow("R9 not yet", ev(16'h4080, 0,0,0,0,0,1,0,0));
    expectNow("R9 collision rises", ev(16'h4080, 0,0,0,0,0,1,0,1));
    cyc();
    expectNow("R9 collision holds", ev(16'h4080, 0,0,0,0,0,1,0,1));
    txEn = 1'b0;
    cyc();
    expectNow("R9 collision released", ev(16'h4080, 0,0,0,0,0,1,0,0));

    wr(0, 16'h0080);
    txEn = 1'b1;
    repeat (COL_D + 2) cyc();
    expectNow("R10 no loopback", ev(16'h0080, 0,0,0,0,0,1,0,0));
    wr(0, 16'h4000);
    repeat (COL_D + 2) cyc();
    expectNow("R10 no coltest bit", ev(16'h4000, 0,0,0,0,0,1,0,0));
    txEn = 1'b0;

    wr(1, 16'h0000);
    regAddr = 1;
    expectNow("R12 other address reads 0", ev(16'h0000, 0,0,0,0,0,1,0,0));
    regAddr = 0;
    expectNow("R12 register unchanged", ev(16'h4000, 0,0,0,0,0,1,0,0));

    cyc();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule